// File: doc/BRIEF.md
# External Trigger Controller

This block serves the two front-panel trigger lines of a bus test card. The trigger input is asynchronous and active on its falling edge. The block resynchronizes it and turns each falling edge into single-clock pulses on a configurable set of card actions. The actions are starting a run, clearing the time-tag counter and arming a one-shot capture. A rising edge on the input does nothing.

The trigger output follows the transmitter. The transmitter reports the first and last word of every wordstring it sends, together with a mark flag for the string. When output triggering is enabled, a marked string produces an active-high pulse of fixed width. The pulse is timed to the string's start (leading mode) or to its end (trailing mode). If another qualifying event arrives while a pulse is still high, the pulse width starts counting again and no second pulse appears. A small register port holds the action mask and the output settings.

Top module: `trig_ctrl`

## Requirements
- R1: After reset all four outputs are low and both configuration registers read zero.
- R2: Address 0 holds the action mask in bits [2:0]: bit 0 is run start, bit 1 is time-tag clear and bit 2 is capture arm. Address 1 holds the output enable in bit 0 and the trailing-mode select in bit 1. Unused bits read zero, and writes to addresses 2 and 3 are ignored and read zero.
- R3: A falling edge on `trig_in_i` drives every action whose mask bit is set high for exactly one clock. The pulse appears in the third cycle after the input changes: two synchronizer stages, then one register. A rising edge causes no action.
- R4: An action whose mask bit is clear stays low.
- R5: Transmit events with `str_mark_i` low never produce an output pulse.
- R6: In leading mode (address 1 bit 1 = 0), a marked string start produces the pulse and string-end events are ignored.
- R7: In trailing mode (address 1 bit 1 = 1), a marked string end produces the pulse and string-start events are ignored.
- R8: The output rises in the cycle after the qualifying event is sampled and stays high for `PULSE_CLKS` clocks (16 by default, 0.5 us at 32 MHz).
- R9: A qualifying event while the pulse is high restarts the width count. The output stays high without a gap and shows one rising edge.
- R10: With the output enable bit clear, no output pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_in_i | input | 1 | External trigger input, asynchronous, falling edge active |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | DW | Register write data |
| cfg_rdata_o | output | DW | Register read data for `cfg_addr_i`, combinational |
| str_start_i | input | 1 | Transmitter sends the first word of a wordstring |
| str_end_i | input | 1 | Transmitter sends the last word of a wordstring |
| str_mark_i | input | 1 | The current wordstring is marked for triggering |
| run_start_o | output | 1 | One-clock run start action |
| tag_clr_o | output | 1 | One-clock time-tag clear action |
| cap_arm_o | output | 1 | One-clock capture arm action |
| trig_out_o | output | 1 | External trigger output pulse, active high |

## Verification
The bench builds the block with its default parameters: `PULSE_CLKS` = 16, `SYNC_STAGES` = 2 and `DW` = 8. A 16-clock pulse lets the bench try retrigger offsets from 1 to 15 cycles, so it covers both an early and a late restart of the width count. Two synchronizer stages fix the input-to-action latency at three cycles, and the bench checks that cycle exactly. The 8-bit data path leaves five unused bits above the mask, so the bench can show that they read back as zero.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int unsigned N_ACT  = 3;
  localparam int unsigned ACT_RUN = 0;
  localparam int unsigned ACT_TAG = 1;
  localparam int unsigned ACT_ARM = 2;

  localparam int unsigned CFG_AW = 2;
  localparam logic [CFG_AW-1:0] ADDR_MASK = 2'd0;
  localparam logic [CFG_AW-1:0] ADDR_OUT  = 2'd1;

  localparam int unsigned OUT_EN_BIT    = 0;
  localparam int unsigned OUT_TRAIL_BIT = 1;

  typedef struct packed {
    logic [N_ACT-1:0] act_mask;
    logic             out_en;
    logic             out_trail;
  } trig_cfg_t;
endpackage

// File: rtl/trig_in_sync.sv
module trig_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  // idle level is high: reset to ones so release gives no false edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], trig_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/trig_action.sv
module trig_action #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fire_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] act_o
);
  for (genvar g = 0; g < N; g++) begin : g_act
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) act_o[g] <= 1'b0;
      else         act_o[g] <= fire_i & mask_i[g];
    end
  end
endmodule

// File: rtl/trig_out_gen.sv
module trig_out_gen #(
  parameter int unsigned PULSE_CLKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic end_i,
  input  logic mark_i,
  input  logic en_i,
  input  logic trail_i,
  output logic evt_o,
  output logic pulse_o
);
  localparam int unsigned CW = $clog2(PULSE_CLKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CLKS);

  logic [CW-1:0] cnt_q;

  assign evt_o = mark_i & en_i & (trail_i ? end_i : start_i);

  // reload on every event: a retrigger stretches, never doubles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (evt_o)           cnt_q <= LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/trig_regs.sv
module trig_regs
  import trig_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output trig_cfg_t         cfg_o
);
  trig_cfg_t cfg_q;
  logic      unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_MASK: cfg_q.act_mask <= wdata_i[N_ACT-1:0];
        ADDR_OUT: begin
          cfg_q.out_en    <= wdata_i[OUT_EN_BIT];
          cfg_q.out_trail <= wdata_i[OUT_TRAIL_BIT];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_MASK: rdata_o[N_ACT-1:0] = cfg_q.act_mask;
      ADDR_OUT: begin
        rdata_o[OUT_EN_BIT]    = cfg_q.out_en;
        rdata_o[OUT_TRAIL_BIT] = cfg_q.out_trail;
      end
      default: ;
    endcase
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PULSE_CLKS  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_in_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [DW-1:0]     cfg_wdata_i,
  output logic [DW-1:0]     cfg_rdata_o,
  input  logic              str_start_i,
  input  logic              str_end_i,
  input  logic              str_mark_i,
  output logic              run_start_o,
  output logic              tag_clr_o,
  output logic              cap_arm_o,
  output logic              trig_out_o
);
  trig_cfg_t        cfg;
  logic             in_fall;
  logic [N_ACT-1:0] act;
  logic             out_evt;

  trig_regs #(.DW(DW)) regs_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .cfg_o   (cfg)
  );

  trig_in_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_in_i),
    .fall_o (in_fall)
  );

  trig_action #(.N(N_ACT)) action_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (in_fall),
    .mask_i (cfg.act_mask),
    .act_o  (act)
  );

  trig_out_gen #(.PULSE_CLKS(PULSE_CLKS)) out_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (str_start_i),
    .end_i   (str_end_i),
    .mark_i  (str_mark_i),
    .en_i    (cfg.out_en),
    .trail_i (cfg.out_trail),
    .evt_o   (out_evt),
    .pulse_o (trig_out_o)
  );

  assign run_start_o = act[ACT_RUN];
  assign tag_clr_o   = act[ACT_TAG];
  assign cap_arm_o   = act[ACT_ARM];
endmodule

// File: rtl/trig_ctrl_chk.sv
module trig_ctrl_chk #(
  parameter int unsigned PULSE_CLKS = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_fall_i,
  input logic [2:0] act_i,
  input logic [2:0] act_mask_i,
  input logic       out_evt_i,
  input logic       out_en_i,
  input logic       trig_out_i
);
  logic [15:0] hi_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            hi_run_q <= '0;
    else if (!trig_out_i)   hi_run_q <= '0;
    else if (hi_run_q != '1) hi_run_q <= hi_run_q + 16'd1;
  end

  for (genvar g = 0; g < 3; g++) begin : g_act_chk
    assert_act_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_i[g] |=> !act_i[g]);
    assert_act_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_i[g] |-> $past(act_mask_i[g]));
  end

  assert_act_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|act_i) |-> $past(in_fall_i));

  assert_out_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_evt_i |=> trig_out_i);

  assert_out_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trig_out_i) |-> $past(out_evt_i));

  assert_out_en_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trig_out_i) |-> $past(out_en_i));

  assert_width_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(trig_out_i) |-> (hi_run_q >= 16'(PULSE_CLKS)));
endmodule

bind trig_ctrl trig_ctrl_chk #(.PULSE_CLKS(PULSE_CLKS)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_fall_i  (in_fall),
  .act_i      (act),
  .act_mask_i (cfg.act_mask),
  .out_evt_i  (out_evt),
  .out_en_i   (cfg.out_en),
  .trig_out_i (trig_out_o)
);

// File: tb/trig_ctrl_tb_top.sv
module trig_ctrl_tb_top;
  localparam int DW    = 8;
  localparam int PULSE = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          trig_in_i = 1'b1;
  logic          cfg_we_i = 1'b0;
  logic [1:0]    cfg_addr_i = '0;
  logic [DW-1:0] cfg_wdata_i = '0;
  logic          str_start_i = 1'b0;
  logic          str_end_i = 1'b0;
  logic          str_mark_i = 1'b0;
  logic [DW-1:0] cfg_rdata_o;
  logic          run_start_o, tag_clr_o, cap_arm_o, trig_out_o;

  int checks = 0;
  int errors = 0;
  int hi_cnt = 0;
  int rise_cnt = 0;
  int act_cnt [3] = '{0, 0, 0};
  logic prev_out = 1'b0;

  trig_ctrl #(.DW(DW), .SYNC_STAGES(2), .PULSE_CLKS(PULSE)) dut_i (
    .clk_i, .rst_ni, .trig_in_i, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .cfg_rdata_o, .str_start_i, .str_end_i, .str_mark_i,
    .run_start_o, .tag_clr_o, .cap_arm_o, .trig_out_o
  );

  always #5 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    if (trig_out_o) hi_cnt++;
    if (trig_out_o && !prev_out) rise_cnt++;
    prev_out = trig_out_o;
    if (run_start_o) act_cnt[0]++;
    if (tag_clr_o)   act_cnt[1]++;
    if (cap_arm_o)   act_cnt[2]++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input int exp);
    @(negedge clk_i);
    cfg_addr_i = a;
    #1;
    chk(req, int'(cfg_rdata_o), exp);
  endtask

  task automatic fire(input logic s, input logic e, input logic m);
    @(negedge clk_i);
    str_start_i = s; str_end_i = e; str_mark_i = m;
    @(negedge clk_i);
    str_start_i = 1'b0; str_end_i = 1'b0; str_mark_i = 1'b0;
  endtask

  function automatic int exp_hi(input bit en, input bit trail, input bit s,
                                input bit e, input bit m);
    if (!en || !m) return 0;
    return (trail ? e : s) ? PULSE : 0;
  endfunction

  task automatic out_case(input string req, input bit en, input bit trail,
                          input bit s, input bit e, input bit m);
    int h0, r0, eh;
    wr(2'd1, {6'b0, trail, en});
    h0 = hi_cnt; r0 = rise_cnt;
    fire(s, e, m);
    repeat (PULSE + 8) @(negedge clk_i);
    eh = exp_hi(en, trail, s, e, m);
    chk({req, " high cycles"}, hi_cnt - h0, eh);
    chk({req, " rising edges"}, rise_cnt - r0, (eh != 0) ? 1 : 0);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int a0 [3];
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 outputs", int'({run_start_o, tag_clr_o, cap_arm_o, trig_out_o}), 0);
    cfg_addr_i = 2'd0; #1;
    chk("R1 mask reg", int'(cfg_rdata_o), 0);
    cfg_addr_i = 2'd1; #1;
    chk("R1 out reg", int'(cfg_rdata_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2 register map
    wr(2'd0, 8'hFF);
    rd_chk("R2 mask readback", 2'd0, 7);
    wr(2'd1, 8'hFF);
    rd_chk("R2 out readback", 2'd1, 3);
    wr(2'd2, 8'hFF);
    rd_chk("R2 addr2 reads zero", 2'd2, 0);
    rd_chk("R2 mask unchanged", 2'd0, 7);
    wr(2'd1, 8'h00);

    // R3 latency, directed
    for (int i = 0; i < 3; i++) a0[i] = act_cnt[i];
    @(negedge clk_i); trig_in_i = 1'b0;
    @(negedge clk_i);
    chk("R3 no action at cycle 1", int'({run_start_o, tag_clr_o, cap_arm_o}), 0);
    @(negedge clk_i);
    chk("R3 no action at cycle 2", int'({run_start_o, tag_clr_o, cap_arm_o}), 0);
    @(negedge clk_i);
    chk("R3 all actions at cycle 3", int'({run_start_o, tag_clr_o, cap_arm_o}), 7);
    @(negedge clk_i);
    chk("R3 one clock only", int'({run_start_o, tag_clr_o, cap_arm_o}), 0);
    repeat (3) @(negedge clk_i);
    trig_in_i = 1'b1;
    repeat (8) @(negedge clk_i);
    for (int i = 0; i < 3; i++)
      chk("R3 rising edge ignored", act_cnt[i] - a0[i], 1);

    // R3 R4 random masks
    for (int it = 0; it < 12; it++) begin
      logic [2:0] m;
      m = 3'($urandom % 8);
      wr(2'd0, {5'b0, m});
      for (int i = 0; i < 3; i++) a0[i] = act_cnt[i];
      @(negedge clk_i); trig_in_i = 1'b0;
      repeat (3 + $urandom % 6) @(negedge clk_i);
      trig_in_i = 1'b1;
      repeat (8) @(negedge clk_i);
      for (int i = 0; i < 3; i++)
        chk(m[i] ? "R3 enabled action count" : "R4 masked action count",
            act_cnt[i] - a0[i], int'(m[i]));
    end

    // directed output cases
    out_case("R6 R8 lead marked start", 1, 0, 1, 0, 1);
    out_case("R6 lead end ignored", 1, 0, 0, 1, 1);
    out_case("R7 trail marked end", 1, 1, 0, 1, 1);
    out_case("R7 trail start ignored", 1, 1, 1, 0, 1);
    out_case("R5 unmarked start", 1, 0, 1, 0, 0);
    out_case("R5 unmarked end", 1, 1, 0, 1, 0);
    out_case("R10 disabled", 0, 0, 1, 0, 1);

    // R9 retrigger at each offset
    wr(2'd1, 8'h01);
    for (int k = 1; k < PULSE; k++) begin
      int h0, r0;
      h0 = hi_cnt; r0 = rise_cnt;
      @(negedge clk_i); str_start_i = 1'b1; str_mark_i = 1'b1;
      @(negedge clk_i); str_start_i = 1'b0; str_mark_i = 1'b0;
      repeat (k - 1) @(negedge clk_i);
      str_start_i = 1'b1; str_mark_i = 1'b1;
      @(negedge clk_i); str_start_i = 1'b0; str_mark_i = 1'b0;
      repeat (PULSE + 8) @(negedge clk_i);
      chk("R9 stretched high cycles", hi_cnt - h0, k + PULSE);
      chk("R9 single rising edge", rise_cnt - r0, 1);
    end

    // random output traffic
    for (int it = 0; it < 30; it++) begin
      bit en, tr, s, e, m;
      en = 1'($urandom % 4 != 0);
      tr = 1'($urandom % 2);
      s  = 1'($urandom % 2);
      e  = 1'($urandom % 2);
      m  = 1'($urandom % 3 != 0);
      out_case("R5 R6 R7 R8 R10 random", en, tr, s, e, m);
    end

    summary();
    $finish;
  end
endmodule